// File: doc/BRIEF.md
# Logical Device I/O Window Decoder

This block maps a 16-bit I/O address onto a fixed set of logical devices. Each device has one I/O window whose size is fixed when the block is built. The size can be 2, 4, 8, 16 or 32 bytes. The block compares the whole address with each device's base. It then reports which enabled device owns the address and the register offset inside that device's window. The hit vector and the offset come from registers, one clock after the address is presented.

Software writes a raw base value for every device. The block turns each raw value into an effective base and drives that value back out, so it can serve as the read-back value. The base bits that fall inside the window are forced to zero, which aligns the base to the window size. Each device also belongs to a class that may clear high base bits:
- The low-range legacy class cannot go above 07FXh.
- The printer-port class cannot go above 3F8h.
- The free class may use the whole 16-bit space.

Decoding always uses the effective base. If enabled windows overlap, the lowest-numbered device wins.

Top module: `iodec_top`

## Requirements
- R1: On a hit, `reg_off` equals the low W bits of the address, where W is the window's log2 size (1 to 5). Offset bits at and above W are zero.
- R2: A device matches only when address bits 15 down to W equal the same bits of its effective base. All 16 address bits take part in the comparison.
- R3: The effective base of each device has its low W bits at zero, whatever the raw value is.
- R4: For class 1 (low-range legacy) devices, effective base bits 15..11 are zero.
- R5: For class 2 (printer-port) devices, effective base bits 15..10 are zero, so with an 8-byte window the largest base is 03F8h.
- R6: For class 0 (free) devices, effective base bits 15..W equal the raw bits.
- R7: A device whose enable is low never asserts its hit, even when its base matches the address.
- R8: When several enabled devices match, only the lowest-numbered one asserts its hit. At most one hit bit is ever high.
- R9: When no enabled device matches, all hit bits are low and `reg_off` is zero.
- R10: Hit and offset appear on the first rising clock edge after the address, enables and base are presented. Synchronous active-low reset clears them to zero.

Default devices, with index, window size and class:
- 0 to 2: 8 bytes, class 1.
- 3: 8 bytes, class 2.
- 4: 2 bytes, class 0.
- 5: 16 bytes, class 0.
- 6: 32 bytes, class 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 16 | I/O address to decode |
| dev_en | input | NDEV (7) | Per-device enable |
| base_raw | input | NDEV*16 (112) | Raw base values, device i at bits [16i+15:16i] |
| base_eff | output | NDEV*16 (112) | Aligned and clamped base values, same packing |
| dev_hit | output | NDEV (7) | One-hot registered hit, bit i for device i |
| reg_off | output | 5 | Registered offset inside the hit window |

## Verification
`base_eff` is combinational, so the bench checks it one time step after it drives new raw values. It does not wait for a clock edge. `dev_hit` and `reg_off` go through a single register. Stimulus changes on the falling edge, and these outputs are compared at the next falling edge, after exactly one rising edge. Every expected value comes from bench functions that rebuild the masks and the priority scan from the requirement text.

// File: rtl/iodec_pkg.sv
// Package iodec_pkg
// Shared constants and helpers for the I/O window decoder.
// Assumes a 16-bit I/O space and 2-bit device class codes.
package iodec_pkg;

    localparam int ADDR_W = 16;

    // Device class codes, which set how far up the base may be placed
    localparam logic [1:0] CLS_FREE   = 2'd0;  // whole 16-bit space
    localparam logic [1:0] CLS_LOW2K  = 2'd1;  // bits 15..11 forced to zero
    localparam logic [1:0] CLS_LOW1K  = 2'd2;  // bits 15..10 forced to zero

    // Mask of the base bits that software may set, for a window of 2**w bytes
    function automatic logic [ADDR_W-1:0] keep_mask(input int unsigned w,
                                                    input logic [1:0] cls);
        logic [ADDR_W-1:0] hi;
        hi = (cls == CLS_LOW2K) ? 16'h07FF :
             (cls == CLS_LOW1K) ? 16'h03FF : 16'hFFFF;
        return hi & ({ADDR_W{1'b1}} << w);
    endfunction

endpackage

// File: rtl/iodec_base_mask.sv
// Module iodec_base_mask
// Turns one device's raw base value into its effective base. The low
// window bits are cleared and the high bits are clamped by device class.
// Assumes WIN_LOG2 is in 1..5. The logic is purely combinational.
module iodec_base_mask #(
    parameter int unsigned WIN_LOG2 = 3,
    parameter logic [1:0]  CLS      = 2'd0
) (
    input  logic [15:0] raw,
    output logic [15:0] eff
);
    import iodec_pkg::*;

    localparam logic [ADDR_W-1:0] KEEP = keep_mask(WIN_LOG2, CLS);

    // Apply the per-device keep mask to the raw value
    always_comb begin
        eff = raw & KEEP;
    end
endmodule

// File: rtl/iodec_match.sv
// Module iodec_match
// Compares the address with one effective base, above the window bits.
// Assumes the base is already aligned. The enable gates the result.
module iodec_match #(
    parameter int unsigned WIN_LOG2 = 3
) (
    input  logic [15:0] addr,
    input  logic [15:0] base,
    input  logic        en,
    output logic        match
);
    localparam logic [15:0] UPPER = 16'hFFFF << WIN_LOG2;

    // Report a match only when enabled and all bits above the window agree
    always_comb begin
        match = en && (((addr ^ base) & UPPER) == 16'h0000);
    end
endmodule

// File: rtl/iodec_arbiter.sv
// Module iodec_arbiter
// Picks the lowest-numbered matching device. It registers a one-hot
// hit and the offset masked to that device's window. Assumes a
// synchronous active-low reset. Hit and offset are zero when nothing matches.
module iodec_arbiter #(
    parameter int unsigned         NDEV     = 7,
    parameter int unsigned         OFF_W    = 5,
    parameter logic [NDEV*3-1:0]   WIN_LOG2 = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [15:0]      addr,
    input  logic [NDEV-1:0]  match,
    output logic [NDEV-1:0]  hit,
    output logic [OFF_W-1:0] off
);
    logic [NDEV-1:0]  hit_nxt;
    logic [OFF_W-1:0] off_nxt;
    logic             found;
    logic [15:0]      lowm;

    // Priority scan from device 0 upward, which selects the window offset
    always_comb begin
        hit_nxt = '0;
        off_nxt = '0;
        found   = 1'b0;
        lowm    = '0;
        for (int i = 0; i < NDEV; i++) begin
            if (!found && match[i]) begin
                found      = 1'b1;
                hit_nxt[i] = 1'b1;
                lowm       = ~(16'hFFFF << WIN_LOG2[3*i +: 3]);
                off_nxt    = OFF_W'(addr & lowm);
            end
        end
    end

    // Output register with synchronous clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit <= '0;
            off <= '0;
        end else begin
            hit <= hit_nxt;
            off <= off_nxt;
        end
    end

    a_r8_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));

    a_r9_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (hit == '0) |-> (off == '0));

    a_r10_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (hit == '0 && off == '0));
endmodule

// File: rtl/iodec_top.sv
// Module iodec_top
// Decodes a 16-bit I/O address against NDEV device windows. Windows
// are 2..32 bytes and sized by parameter. The module outputs the
// aligned and clamped bases, a one-cycle-late one-hot hit and the
// register offset. Assumes a synchronous active-low reset.
module iodec_top #(
    parameter int unsigned       NDEV     = 7,
    parameter int unsigned       MAX_LOG2 = 5,
    parameter logic [NDEV*3-1:0] WIN_LOG2 = {3'd5, 3'd4, 3'd1, 3'd3, 3'd3, 3'd3, 3'd3},
    parameter logic [NDEV*2-1:0] DEV_CLS  = {2'd0, 2'd0, 2'd0, 2'd2, 2'd1, 2'd1, 2'd1}
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [15:0]          io_addr,
    input  logic [NDEV-1:0]      dev_en,
    input  logic [NDEV*16-1:0]   base_raw,
    output logic [NDEV*16-1:0]   base_eff,
    output logic [NDEV-1:0]      dev_hit,
    output logic [MAX_LOG2-1:0]  reg_off
);
    localparam int unsigned OFF_W = MAX_LOG2;

    logic [NDEV-1:0] match;

    for (genvar i = 0; i < NDEV; i++) begin : g_dev
        localparam int unsigned W   = int'(WIN_LOG2[3*i +: 3]);
        localparam logic [1:0]  CLS = DEV_CLS[2*i +: 2];
        localparam logic [15:0] LOWM = ~(16'hFFFF << W);

        iodec_base_mask #(.WIN_LOG2(W), .CLS(CLS)) u_mask (
            .raw (base_raw[16*i +: 16]),
            .eff (base_eff[16*i +: 16])
        );

        iodec_match #(.WIN_LOG2(W)) u_match (
            .addr  (io_addr),
            .base  (base_eff[16*i +: 16]),
            .en    (dev_en[i]),
            .match (match[i])
        );

        a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(dev_en[i]) |-> !dev_hit[i]);

        a_r2_full_compare: assert property (@(posedge clk) disable iff (!rst_n)
            dev_hit[i] |-> ((($past(io_addr) ^ $past(base_eff[16*i +: 16])) & ~LOWM) == 16'h0));

        a_r1_offset: assert property (@(posedge clk) disable iff (!rst_n)
            dev_hit[i] |-> (16'(reg_off) == ($past(io_addr) & LOWM)));
    end

    iodec_arbiter #(.NDEV(NDEV), .OFF_W(OFF_W), .WIN_LOG2(WIN_LOG2)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (io_addr),
        .match (match),
        .hit   (dev_hit),
        .off   (reg_off)
    );
endmodule

// File: tb/tb_iodec_top.sv
module tb_iodec_top;
    localparam int NDEV = 7;
    localparam int WIN[NDEV] = '{3, 3, 3, 3, 1, 4, 5};
    localparam int CLS[NDEV] = '{1, 1, 1, 2, 0, 0, 0};

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [15:0]         io_addr = '0;
    logic [NDEV-1:0]     dev_en = '0;
    logic [NDEV*16-1:0]  base_raw = '0;
    logic [NDEV*16-1:0]  base_eff;
    logic [NDEV-1:0]     dev_hit;
    logic [4:0]          reg_off;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    iodec_top dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .dev_en(dev_en),
        .base_raw(base_raw), .base_eff(base_eff), .dev_hit(dev_hit), .reg_off(reg_off)
    );

    function automatic logic [15:0] ref_base(int i, logic [15:0] raw);
        logic [15:0] m;
        m = 16'hFFFF << WIN[i];                  // R3
        if (CLS[i] == 1) m &= 16'h07FF;          // R4
        else if (CLS[i] == 2) m &= 16'h03FF;     // R5
        return raw & m;                          // R6 for class 0
    endfunction

    function automatic logic [NDEV-1:0] ref_hit(logic [15:0] a, logic [NDEV-1:0] en,
                                                logic [NDEV*16-1:0] raw);
        for (int i = 0; i < NDEV; i++)
            if (en[i] && ((a >> WIN[i]) == (ref_base(i, raw[16*i +: 16]) >> WIN[i])))
                return NDEV'(1) << i;            // R7, R8
        return '0;
    endfunction

    function automatic logic [4:0] ref_off(logic [15:0] a, logic [NDEV-1:0] h);
        for (int i = 0; i < NDEV; i++)
            if (h[i]) return 5'(a & ~(16'hFFFF << WIN[i]));  // R1
        return 5'd0;                                          // R9
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive at negedge, check bases after 1 time unit, outputs at next negedge (R10)
    task automatic apply(logic [15:0] a, logic [NDEV-1:0] en, logic [NDEV*16-1:0] raw,
                         string req);
        logic [NDEV-1:0] eh;
        @(negedge clk);
        io_addr = a; dev_en = en; base_raw = raw;
        #1;
        for (int i = 0; i < NDEV; i++)
            chk("R3/R4/R5/R6 base", 32'(base_eff[16*i +: 16]), 32'(ref_base(i, raw[16*i +: 16])));
        eh = ref_hit(a, en, raw);
        @(negedge clk);
        chk({req, " hit"}, 32'(dev_hit), 32'(eh));
        chk({req, " off"}, 32'(reg_off), 32'(ref_off(a, eh)));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [NDEV*16-1:0] raw;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk("R10 reset hit", 32'(dev_hit), 32'h0);
        chk("R10 reset off", 32'(reg_off), 32'h0);
        rst_n = 1'b1;

        raw = {NDEV*16{1'b1}};
        // R5 parallel max 03F8, R4 0x07F8, R6 free 0xFFE0
        @(negedge clk); base_raw = raw; #1;
        chk("R5 par clamp", 32'(base_eff[16*3 +: 16]), 32'h03F8);
        chk("R4 legacy clamp", 32'(base_eff[16*0 +: 16]), 32'h07F8);
        chk("R6 free full", 32'(base_eff[16*6 +: 16]), 32'hFFE0);
        chk("R3 align 2B", 32'(base_eff[16*4 +: 16]), 32'hFFFE);

        // R1 largest offset in 32-byte window, R2 boundary
        raw = '0; raw[16*6 +: 16] = 16'hA05F;   // eff A040
        apply(16'hA05F, 7'b1000000, raw, "R1 top of window");
        apply(16'hA060, 7'b1000000, raw, "R2 one past window");
        apply(16'h2040, 7'b1000000, raw, "R2 high bit differs");

        // R7 disabled device with matching base
        raw = '0; raw[16*1 +: 16] = 16'h03F8;
        apply(16'h03FC, 7'b0000000, raw, "R7 disabled");
        apply(16'h03FC, 7'b0000010, raw, "R7 enabled");

        // R8 overlap: dev0 and dev1 same base, dev5 (16B) covers it too
        raw = '0; raw[16*0 +: 16] = 16'h02F8; raw[16*1 +: 16] = 16'h02F8;
        raw[16*5 +: 16] = 16'h02F0;
        apply(16'h02FB, 7'b0100011, raw, "R8 lowest wins");
        apply(16'h02FB, 7'b0100010, raw, "R8 next wins");
        apply(16'h02F3, 7'b0100011, raw, "R8 only dev5");

        // R9 miss
        apply(16'h1234, 7'b1111111, raw, "R9 miss");

        // R4: address above clamp never matches a legacy device
        raw = '0; raw[16*2 +: 16] = 16'hFFF8;
        apply(16'hFFF8, 7'b0000100, raw, "R4 clamp decode");
        apply(16'h07F9, 7'b0000100, raw, "R4 clamp hit");

        // Random mix, half aimed at a device's window
        for (int k = 0; k < 3000; k++) begin
            logic [15:0] a;
            logic [NDEV-1:0] en;
            int d;
            for (int i = 0; i < NDEV; i++) raw[16*i +: 16] = 16'($urandom);
            if (($urandom % 4) == 0)
                for (int i = 1; i < NDEV; i++) raw[16*i +: 16] = raw[15:0];
            en = NDEV'($urandom);
            d = int'($urandom % NDEV);
            a = 16'($urandom);
            if ($urandom % 2)
                a = ref_base(d, raw[16*d +: 16]) | (a & ~(16'hFFFF << WIN[d]));
            apply(a, en, raw, "R2/R8 random");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule